// File: doc/BRIEF.md
# Raster Combine and Mask Datapath

This block is the word-wide combining stage of a rectangle-transfer engine. Each cycle it takes an already aligned source word, a word from a small pattern memory and the current destination word, and forms one new destination word. The source and pattern words are first merged under a 2-bit selector. A 4-bit boolean rule then combines that merged word with the destination. A write mask finally chooses, bit by bit, between the rule result and the old destination bit. The result is registered, so it appears one cycle after the inputs.

The pattern memory holds 16 words of 16 bits. It is written and read back one whole word at a time through a register port with a 4-bit index. The word used by the datapath comes from a 4-bit line index. That index steps up or down at the end of each line and wraps through zero. When the smudge control is set, the low four bits of the source word choose the pattern word instead. A combinational flag tells the surrounding engine whether the current word needs the destination read from memory first. Address generation, source alignment and bus access belong to other blocks.

Top module: `rcm_top`

## Requirements
- R1: After reset, `res_o` is 0, `res_valid_o` is 0, `line_idx_o` is 0, smudge is off, and every pattern word reads back as 0.
- R2: The rule is a truth table on the merged word t and the destination d. `rule_i[3]` gives the result for t=0,d=0, `rule_i[2]` for t=0,d=1, `rule_i[1]` for t=1,d=0 and `rule_i[0]` for t=1,d=1. So rule 3 passes t, 5 passes d, 6 is XOR, 0 gives zeros and 15 gives ones.
- R3: When `cfg_we_i` is 1, word `cfg_wdata_i` is written at index `cfg_idx_i` on the clock edge. `cfg_rdata_o` shows the word at `cfg_idx_i` with no delay, so a write can be read back from the next cycle on.
- R4: The selector sets t as follows: `mix_sel_i`=0 gives all ones, 1 gives the pattern word, 2 gives the source word and 3 gives source AND pattern.
- R5: Where a bit of `mask_i` is 1, the output bit is the rule result. Where it is 0, the output bit keeps the old bit of `dst_i`.
- R6: If `line_ld_i` is 1, the line index is loaded from `line_val_i`. Otherwise, if `line_end_i` is 1, the index steps by one modulo 16. It counts down when `line_neg_i` is 1 and up when `line_neg_i` is 0. With neither input set, the index holds.
- R7: The smudge bit is loaded from `smudge_val_i` together with the line index. While smudge is set, `src_i[3:0]` chooses the pattern word in place of the line index, and the selector still applies.
- R8: `need_rd_o` is 1 when `mask_i` is not all ones. It is also 1 when the rule depends on d, which happens when `rule_i[3]` differs from `rule_i[2]` or `rule_i[1]` differs from `rule_i[0]`. In every other case it is 0. It is combinational.
- R9: `res_o` and `res_valid_o` are updated one clock after `valid_i` is sampled. `res_valid_o` follows `valid_i` with this one-cycle delay, and `res_o` holds its value while `valid_i` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cfg_we_i | input | 1 | Pattern word write strobe |
| cfg_idx_i | input | 4 | Pattern word index for write and read back |
| cfg_wdata_i | input | 16 | Pattern word to write |
| cfg_rdata_o | output | 16 | Pattern word at cfg_idx_i |
| line_ld_i | input | 1 | Load line index and smudge bit |
| line_val_i | input | 4 | Line index load value |
| smudge_val_i | input | 1 | Smudge bit load value |
| line_end_i | input | 1 | End of line, steps the index |
| line_neg_i | input | 1 | Destination line step is negative, so the index counts down |
| line_idx_o | output | 4 | Current line index |
| valid_i | input | 1 | Datapath inputs are valid |
| mix_sel_i | input | 2 | Source/pattern selector |
| rule_i | input | 4 | Boolean rule truth table |
| mask_i | input | 16 | Active write mask |
| src_i | input | 16 | Aligned source word |
| dst_i | input | 16 | Current destination word |
| res_o | output | 16 | New destination word |
| res_valid_o | output | 1 | res_o was updated by the previous cycle's inputs |
| need_rd_o | output | 1 | The destination word must be read |

## Verification
Some properties are checked on every cycle. Masked-off bits must keep the destination bit sampled one cycle earlier. Rule 15 with a full mask must give all ones. The line index must hold, step up or step down as its controls say. The read-need flag must match the mask, and a pattern write must read back at the same index. Other behaviour is shown only by the bench scenarios. Those cover the mapping of each rule bit to its truth-table row and each selector code. They also cover the choice of the pattern word through the line index or through the source bits under smudge, the wrap of the index at both ends, and the priority of a load over a step.

// File: rtl/rcm_pkg.sv
package rcm_pkg;
  localparam int unsigned DATA_W_DEF = 16;
  localparam int unsigned PAT_DEPTH_DEF = 16;

  typedef enum logic [1:0] {
    MIX_ONES = 2'd0,
    MIX_PAT  = 2'd1,
    MIX_SRC  = 2'd2,
    MIX_AND  = 2'd3
  } mix_e;
endpackage

// File: rtl/rcm_line_ctr.sv
module rcm_line_ctr #(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_i,
  input  logic [IDX_W-1:0] ld_val_i,
  input  logic             smudge_val_i,
  input  logic             end_i,
  input  logic             neg_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             smudge_o
);
  logic [IDX_W-1:0] idx_q;
  logic             smudge_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q    <= '0;
      smudge_q <= 1'b0;
    end else if (ld_i) begin
      idx_q    <= ld_val_i;
      smudge_q <= smudge_val_i;
    end else if (end_i) begin
      idx_q <= neg_i ? idx_q - 1'b1 : idx_q + 1'b1;
    end
  end

  assign idx_o    = idx_q;
  assign smudge_o = smudge_q;
endmodule

// File: rtl/rcm_pat_mem.sv
module rcm_pat_mem #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned DEPTH  = 16,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_a_i,
  output logic [DATA_W-1:0] rdata_a_o,
  input  logic [IDX_W-1:0]  ridx_b_i,
  output logic [DATA_W-1:0] rdata_b_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  mem_q[g] <= '0;
      else if (we_i && (widx_i == IDX_W'(g)))       mem_q[g] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[ridx_a_i];
  assign rdata_b_o = mem_q[ridx_b_i];
endmodule

// File: rtl/rcm_logic.sv
module rcm_logic
  import rcm_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic [1:0]        sel_i,
  input  logic [3:0]        rule_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] pat_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              need_rd_o
);
  logic [DATA_W-1:0] mix;
  logic [DATA_W-1:0] rop;

  always_comb begin
    unique case (mix_e'(sel_i))
      MIX_ONES: mix = '1;
      MIX_PAT:  mix = pat_i;
      MIX_SRC:  mix = src_i;
      default:  mix = src_i & pat_i;
    endcase
  end

  // rule bit index is the inverted {t,d} pair
  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    assign rop[b] = rule_i[~{mix[b], dst_i[b]}];
  end

  assign res_o     = (rop & mask_i) | (dst_i & ~mask_i);
  assign need_rd_o = (mask_i != '1) ||
                     ({rule_i[3], rule_i[1]} != {rule_i[2], rule_i[0]});
endmodule

// File: rtl/rcm_top.sv
module rcm_top
  import rcm_pkg::*;
#(
  parameter int unsigned DATA_W    = DATA_W_DEF,
  parameter int unsigned PAT_DEPTH = PAT_DEPTH_DEF,
  localparam int unsigned IDX_W    = $clog2(PAT_DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [IDX_W-1:0]  cfg_idx_i,
  input  logic [DATA_W-1:0] cfg_wdata_i,
  output logic [DATA_W-1:0] cfg_rdata_o,
  input  logic              line_ld_i,
  input  logic [IDX_W-1:0]  line_val_i,
  input  logic              smudge_val_i,
  input  logic              line_end_i,
  input  logic              line_neg_i,
  output logic [IDX_W-1:0]  line_idx_o,
  input  logic              valid_i,
  input  logic [1:0]        mix_sel_i,
  input  logic [3:0]        rule_i,
  input  logic [DATA_W-1:0] mask_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [DATA_W-1:0] dst_i,
  output logic [DATA_W-1:0] res_o,
  output logic              res_valid_o,
  output logic              need_rd_o
);
  logic              smudge;
  logic [IDX_W-1:0]  pat_idx;
  logic [DATA_W-1:0] pat_word;
  logic [DATA_W-1:0] res_d;
  logic [DATA_W-1:0] res_q;
  logic              vld_q;

  rcm_line_ctr #(.IDX_W(IDX_W)) u_line (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .ld_i         (line_ld_i),
    .ld_val_i     (line_val_i),
    .smudge_val_i (smudge_val_i),
    .end_i        (line_end_i),
    .neg_i        (line_neg_i),
    .idx_o        (line_idx_o),
    .smudge_o     (smudge)
  );

  assign pat_idx = smudge ? src_i[IDX_W-1:0] : line_idx_o;

  rcm_pat_mem #(.DATA_W(DATA_W), .DEPTH(PAT_DEPTH)) u_pat (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .widx_i    (cfg_idx_i),
    .wdata_i   (cfg_wdata_i),
    .ridx_a_i  (cfg_idx_i),
    .rdata_a_o (cfg_rdata_o),
    .ridx_b_i  (pat_idx),
    .rdata_b_o (pat_word)
  );

  rcm_logic #(.DATA_W(DATA_W)) u_logic (
    .sel_i     (mix_sel_i),
    .rule_i    (rule_i),
    .mask_i    (mask_i),
    .src_i     (src_i),
    .pat_i     (pat_word),
    .dst_i     (dst_i),
    .res_o     (res_d),
    .need_rd_o (need_rd_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_q <= '0;
      vld_q <= 1'b0;
    end else begin
      vld_q <= valid_i;
      if (valid_i) res_q <= res_d;
    end
  end

  assign res_o       = res_q;
  assign res_valid_o = vld_q;
endmodule

// File: rtl/rcm_checker.sv
module rcm_checker #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned IDX_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cfg_we_i,
  input logic [IDX_W-1:0]  cfg_idx_i,
  input logic [DATA_W-1:0] cfg_wdata_i,
  input logic [DATA_W-1:0] cfg_rdata_o,
  input logic              line_ld_i,
  input logic              line_end_i,
  input logic              line_neg_i,
  input logic [IDX_W-1:0]  line_idx_o,
  input logic              valid_i,
  input logic [3:0]        rule_i,
  input logic [DATA_W-1:0] mask_i,
  input logic [DATA_W-1:0] dst_i,
  input logic [DATA_W-1:0] res_o,
  input logic              res_valid_o,
  input logic              need_rd_o
);
  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (res_valid_o == $past(valid_i))); // R9

  AST_RES_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> $stable(res_o)); // R9

  AST_MASK_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> (((res_o ^ $past(dst_i)) & ~$past(mask_i)) == '0)); // R5

  AST_RULE_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rule_i == 4'hF && mask_i == '1) |=> (res_o == '1)); // R2

  AST_LINE_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_ld_i && line_end_i && !line_neg_i) |=>
      (line_idx_o == $past(line_idx_o) + 1'b1)); // R6

  AST_LINE_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_ld_i && line_end_i && line_neg_i) |=>
      (line_idx_o == $past(line_idx_o) - 1'b1)); // R6

  AST_LINE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!line_ld_i && !line_end_i) |=> $stable(line_idx_o)); // R6

  AST_PART_MASK_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i != '1) |-> need_rd_o); // R8

  AST_CONST_NO_RD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mask_i == '1 && (rule_i == 4'h0 || rule_i == 4'hF || rule_i == 4'h3)) |-> !need_rd_o); // R8

  AST_PAT_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_we_i |=> (cfg_idx_i != $past(cfg_idx_i) || cfg_rdata_o == $past(cfg_wdata_i))); // R3
endmodule

bind rcm_top rcm_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_rcm_checker (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .cfg_we_i    (cfg_we_i),
  .cfg_idx_i   (cfg_idx_i),
  .cfg_wdata_i (cfg_wdata_i),
  .cfg_rdata_o (cfg_rdata_o),
  .line_ld_i   (line_ld_i),
  .line_end_i  (line_end_i),
  .line_neg_i  (line_neg_i),
  .line_idx_o  (line_idx_o),
  .valid_i     (valid_i),
  .rule_i      (rule_i),
  .mask_i      (mask_i),
  .dst_i       (dst_i),
  .res_o       (res_o),
  .res_valid_o (res_valid_o),
  .need_rd_o   (need_rd_o)
);

// File: tb/tb_rcm_top.sv
`timescale 1ns/1ps
module tb_rcm_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [3:0]  cfg_idx_i = '0;
  logic [15:0] cfg_wdata_i = '0;
  logic [15:0] cfg_rdata_o;
  logic        line_ld_i = 1'b0;
  logic [3:0]  line_val_i = '0;
  logic        smudge_val_i = 1'b0;
  logic        line_end_i = 1'b0;
  logic        line_neg_i = 1'b0;
  logic [3:0]  line_idx_o;
  logic        valid_i = 1'b0;
  logic [1:0]  mix_sel_i = '0;
  logic [3:0]  rule_i = '0;
  logic [15:0] mask_i = '1;
  logic [15:0] src_i = '0;
  logic [15:0] dst_i = '0;
  logic [15:0] res_o;
  logic        res_valid_o;
  logic        need_rd_o;

  int unsigned n_chk = 0;
  int unsigned n_bad = 0;
  logic [15:0] pat_m [16];

  always #2 clk_i = ~clk_i;

  rcm_top dut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic logic [15:0] mix_f(input logic [1:0] sel, input logic [15:0] s, input logic [15:0] p);
    case (sel)
      2'd0: return 16'hFFFF;
      2'd1: return p;
      2'd2: return s;
      default: return s & p;
    endcase
  endfunction

  function automatic logic [15:0] exp_f(input logic [1:0] sel, input logic [3:0] rule,
      input logic [15:0] m, input logic [15:0] s, input logic [15:0] p, input logic [15:0] d);
    logic [15:0] t, r;
    t = mix_f(sel, s, p);
    r = (~t & ~d & {16{rule[3]}}) | (~t & d & {16{rule[2]}}) |
        ( t & ~d & {16{rule[1]}}) | ( t & d & {16{rule[0]}});
    return (r & m) | (d & ~m);
  endfunction

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [15:0] sv [4];
    logic [15:0] dv [4];
    logic [15:0] mv [4];
    sv[0] = 16'hF0F0; sv[1] = 16'h3C5A; sv[2] = 16'hFFFF; sv[3] = 16'h0123;
    dv[0] = 16'hCCCC; dv[1] = 16'h0000; dv[2] = 16'hA5A5; dv[3] = 16'hFEDC;
    mv[0] = 16'hFFFF; mv[1] = 16'h00FF; mv[2] = 16'h8001; mv[3] = 16'h0000;

    @(negedge clk_i);
    // R1 reset state
    chk("R1 res", {16'h0, res_o}, 32'h0);
    chk("R1 valid", {31'h0, res_valid_o}, 32'h0);
    chk("R1 line", {28'h0, line_idx_o}, 32'h0);
    for (int i = 0; i < 16; i++) begin
      cfg_idx_i = 4'(i); #1;
      chk("R1 pat", {16'h0, cfg_rdata_o}, 32'h0);
    end
    rst_ni = 1'b1;
    step();

    // R3 write all pattern words, read back
    for (int i = 0; i < 16; i++) begin
      pat_m[i] = 16'((i * 16'h1357) ^ 16'hA0C3 ^ (i << 12));
      cfg_we_i = 1'b1; cfg_idx_i = 4'(i); cfg_wdata_i = pat_m[i];
      step();
    end
    cfg_we_i = 1'b0;
    for (int i = 15; i >= 0; i--) begin
      cfg_idx_i = 4'(i); #1;
      chk("R3 readback", {16'h0, cfg_rdata_o}, {16'h0, pat_m[i]});
    end

    // load line index 5, no smudge
    line_ld_i = 1'b1; line_val_i = 4'd5; smudge_val_i = 1'b0;
    step();
    line_ld_i = 1'b0;
    chk("R6 load", {28'h0, line_idx_o}, 32'd5);

    // R2 R4 R5 R9 sweep
    for (int sel = 0; sel < 4; sel++)
      for (int rule = 0; rule < 16; rule++)
        for (int k = 0; k < 4; k++) begin
          valid_i = 1'b1; mix_sel_i = 2'(sel); rule_i = 4'(rule);
          src_i = sv[k] ^ 16'(rule << 4); dst_i = dv[(k + sel) % 4];
          mask_i = mv[(k + rule) % 4];
          begin
            logic [15:0] e;
            e = exp_f(2'(sel), 4'(rule), mask_i, src_i, pat_m[5], dst_i);
            step();
            chk("R2/R4/R5 result", {16'h0, res_o}, {16'h0, e});
            chk("R9 valid", {31'h0, res_valid_o}, 32'h1);
          end
        end

    // R9 hold while not valid
    begin
      logic [15:0] prev;
      prev = res_o;
      valid_i = 1'b0; src_i = 16'h5555; dst_i = 16'h1111; rule_i = 4'hF; mask_i = '1;
      step();
      chk("R9 idle valid", {31'h0, res_valid_o}, 32'h0);
      chk("R9 idle hold", {16'h0, res_o}, {16'h0, prev});
    end

    // R7 smudge: src low bits pick pattern word
    line_ld_i = 1'b1; line_val_i = 4'd9; smudge_val_i = 1'b1;
    step();
    line_ld_i = 1'b0;
    for (int s = 0; s < 16; s++) begin
      valid_i = 1'b1; mix_sel_i = 2'd1; rule_i = 4'h3; mask_i = '1;
      src_i = {12'hB70, 4'(s)}; dst_i = 16'h0F0F;
      step();
      chk("R7 smudge pat", {16'h0, res_o}, {16'h0, pat_m[s]});
    end
    // selector still applies under smudge
    mix_sel_i = 2'd3; src_i = 16'hFF3C; rule_i = 4'h3;
    step();
    chk("R7 smudge and", {16'h0, res_o}, {16'h0, 16'hFF3C & pat_m[12]});
    // smudge cleared: line index again
    line_ld_i = 1'b1; line_val_i = 4'd2; smudge_val_i = 1'b0;
    step();
    line_ld_i = 1'b0; mix_sel_i = 2'd1; src_i = 16'h0007;
    step();
    chk("R7 smudge off", {16'h0, res_o}, {16'h0, pat_m[2]});
    valid_i = 1'b0;

    // R6 stepping and wrap
    line_ld_i = 1'b1; line_val_i = 4'd14;
    step();
    line_ld_i = 1'b0; line_end_i = 1'b1; line_neg_i = 1'b0;
    step(); chk("R6 up 15", {28'h0, line_idx_o}, 32'd15);
    step(); chk("R6 up wrap 0", {28'h0, line_idx_o}, 32'd0);
    step(); chk("R6 up 1", {28'h0, line_idx_o}, 32'd1);
    line_neg_i = 1'b1;
    step(); chk("R6 down 0", {28'h0, line_idx_o}, 32'd0);
    step(); chk("R6 down wrap 15", {28'h0, line_idx_o}, 32'd15);
    line_end_i = 1'b0;
    step(); chk("R6 hold", {28'h0, line_idx_o}, 32'd15);
    line_ld_i = 1'b1; line_val_i = 4'd7; line_end_i = 1'b1;
    step(); chk("R6 load priority", {28'h0, line_idx_o}, 32'd7);
    line_ld_i = 1'b0; line_end_i = 1'b0;
    // stepped index selects pattern
    valid_i = 1'b1; mix_sel_i = 2'd1; rule_i = 4'h3; mask_i = '1;
    step();
    chk("R6 index picks pat", {16'h0, res_o}, {16'h0, pat_m[7]});
    valid_i = 1'b0;

    // R8 read-need flag
    for (int rule = 0; rule < 16; rule++)
      for (int k = 0; k < 4; k++) begin
        logic [3:0] r;
        logic e;
        r = 4'(rule);
        rule_i = r; mask_i = mv[k]; #1;
        e = (mv[k] != 16'hFFFF) || (r[3] != r[2]) || (r[1] != r[0]);
        chk("R8 need_rd", {31'h0, need_rd_o}, {31'h0, e});
      end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule